// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block drives a single read or write access onto a 16-bit asynchronous external bus region. A client issues a request with an address, write data and a direction bit. The sequencer then steps through five timed phases. Address setup comes first, then chip enable with a lead-in before the strobe. The read or write strobe follows, then a hold, then a closing pause. At the end the block returns read data together with a one-cycle completion pulse.

Each phase length is a 6-bit field in minus-one form. A field value of n lasts n+1 base units. A base unit is 1, 2, 4 or 8 clocks, chosen by a 2-bit scale code. A slow device can stretch the strobe by holding its ready line low, but only when wait tracking is switched on. A watchdog ends a wait that never finishes and reports it. The timing inputs are captured when a request is accepted, so changing them during a cycle does not affect that cycle.

Top module: `ebus_seq`

## Requirements
- R1: A cycle runs its phases in this order: address setup, chip-enable lead-in, strobe, hold, pause. `bus_ce_n` is low for the lead-in, strobe and hold phases only. The strobe (`bus_oe_n` or `bus_we_n`) is low only while `bus_ce_n` is low.
- R2: Each phase lasts (field+1) base units. The hold phase uses `cfg_rd_hold` for reads and `cfg_wr_hold` for writes. `done` goes high in the first clock after the pause ends.
- R3: The scale code `cfg_scale` sets the clocks per base unit: 0 gives 4, 1 gives 1, 2 gives 2 and 3 gives 8.
- R4: A read (`req_write`=0) drives only `bus_oe_n` low. A write (`req_write`=1) drives only `bus_we_n` low. The two are never low together.
- R5: When `cfg_wait_en`=1 and `bus_rdy` is low, the strobe stays asserted past its programmed length. `bus_rdy` passes through a two-flop synchronizer. After `bus_rdy` rises, the strobe ends within three clocks (at scale 1).
- R6: When `cfg_wait_en`=0, `bus_rdy` has no effect on any phase length.
- R7: On a read, `rd_data` takes the value of `bus_din` at the clock edge where `bus_oe_n` goes high. Later changes on `bus_din` do not alter it.
- R8: While `cfg_region_en`=0, `req_ready` is 0, no request is accepted and `bus_ce_n` stays high.
- R9: `done` is a one-clock pulse. `req_ready` is 0 from acceptance until the pause phase has completed.
- R10: If the strobe is stretched by 256 base units beyond its programmed length, the strobe is ended. The cycle then completes normally, and `timeout_err` is 1 in the same clock as `done`.
- R11: During a write, `bus_dout_en` is high exactly while `bus_ce_n` is low, and `bus_dout` carries the request data. `bus_addr` holds the request address throughout the cycle.
- R12: After reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are 1, and `done`, `timeout_err` and `bus_dout_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_region_en | input | 1 | Region enable |
| cfg_wait_en | input | 1 | Ready-driven strobe stretching enable |
| cfg_scale | input | 2 | Clocks-per-unit code |
| cfg_addr_setup | input | 6 | Address setup units, minus one |
| cfg_ce_lead | input | 6 | Chip enable to strobe units, minus one |
| cfg_strobe | input | 6 | Strobe units, minus one |
| cfg_rd_hold | input | 6 | Read hold units, minus one |
| cfg_wr_hold | input | 6 | Write hold units, minus one |
| cfg_pause | input | 6 | Pause units, minus one |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Request accepted this clock if valid |
| done | output | 1 | Cycle complete pulse |
| timeout_err | output | 1 | Wait watchdog fired in this cycle |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dout | output | DATA_W | Data driven to the bus |
| bus_dout_en | output | 1 | Bus data drive enable |
| bus_din | input | DATA_W | Data from the bus |
| bus_rdy | input | 1 | Device ready, asynchronous |

## Verification
A corrupt phase counter or timer shows up at the pins within a single base unit: a chip-enable or strobe window of the wrong length, or a `done` that arrives early or late. The bench measures these windows clock by clock against (field+1) times the scale. A wrong state decode shows as a strobe outside chip enable, or both strobes low at once, on the first bad clock. Faults in read capture or in the wait counter appear only at cycle end. They show as stale `rd_data`, a strobe that ends at the wrong time, or a missing `timeout_err` in the `done` clock.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    localparam int FIELD_W = 6;
    localparam int SCALE_W = 2;
    localparam int TICK_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ADDR   = 3'd1,
        PH_LEAD   = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4,
        PH_PAUSE  = 3'd5
    } phase_e;

    typedef struct packed {
        logic               wait_en;
        logic [SCALE_W-1:0] scale;
        logic [FIELD_W-1:0] addr_setup;
        logic [FIELD_W-1:0] ce_lead;
        logic [FIELD_W-1:0] strobe;
        logic [FIELD_W-1:0] rd_hold;
        logic [FIELD_W-1:0] wr_hold;
        logic [FIELD_W-1:0] pause;
    } timing_t;

    function automatic logic [TICK_W-1:0] scale_clocks(input logic [SCALE_W-1:0] code);
        case (code)
            2'd0:    return 4'd4;
            2'd1:    return 4'd1;
            2'd2:    return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] phase_field(input phase_e ph, input timing_t t,
                                                       input logic wr);
        case (ph)
            PH_ADDR:   return t.addr_setup;
            PH_LEAD:   return t.ce_lead;
            PH_STROBE: return t.strobe;
            PH_HOLD:   return wr ? t.wr_hold : t.rd_hold;
            PH_PAUSE:  return t.pause;
            default:   return '0;
        endcase
    endfunction

    function automatic logic ce_window(input phase_e ph);
        return (ph == PH_LEAD) || (ph == PH_STROBE) || (ph == PH_HOLD);
    endfunction

endpackage

// File: rtl/ebus_rdy_sync.sv
module ebus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rdy_async,
    output logic rdy_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], rdy_async};
    end

    assign rdy_sync = chain[STAGES-1];
endmodule

// File: rtl/ebus_phase_timer.sv
module ebus_phase_timer
    import ebus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_units,
    input  logic [TICK_W-1:0]  unit_clocks,
    input  logic               restart_unit,
    output logic               at_end
);
    localparam int TC_W = TICK_W - 1;

    logic [TC_W-1:0]    tick_q;
    logic [FIELD_W-1:0] unit_q;
    logic [TICK_W-1:0]  reload_full;
    logic [TC_W-1:0]    reload;

    assign reload_full = unit_clocks - 4'd1;
    assign reload      = reload_full[TC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            unit_q <= '0;
        end else if (load) begin
            tick_q <= reload;
            unit_q <= load_units;
        end else if (tick_q != '0) begin
            tick_q <= tick_q - 1'b1;
        end else if (unit_q != '0) begin
            unit_q <= unit_q - 1'b1;
            tick_q <= reload;
        end else if (restart_unit) begin
            tick_q <= reload;
        end
    end

    assign at_end = (tick_q == '0) && (unit_q == '0);

    assert_load_units_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (unit_q == $past(load_units)));
    assert_scale_code_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> (unit_clocks == 4'd1 || unit_clocks == 4'd2 ||
                  unit_clocks == 4'd4 || unit_clocks == 4'd8));
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
    import ebus_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int WAIT_LIMIT = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               region_en,
    input  timing_t            live_cfg,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               rdy_sync,
    input  logic               at_end,
    output logic               accept_ok,
    output logic               tmr_load,
    output logic [FIELD_W-1:0] tmr_units,
    output logic [TICK_W-1:0]  tmr_clocks,
    output logic               tmr_restart,
    output phase_e             phase_nxt,
    output logic               wr_q,
    output logic [ADDR_W-1:0]  addr_q,
    output logic [DATA_W-1:0]  wdata_q,
    output logic               capture,
    output logic               finish,
    output logic               aborted
);
    localparam int WC_W = $clog2(WAIT_LIMIT + 1);
    localparam logic [WC_W-1:0] WLIM = WC_W'(WAIT_LIMIT);

    phase_e            phase_q;
    timing_t           cfg_q;
    logic [WC_W-1:0]   wcnt_q;
    logic              err_q;
    logic              accept, advance, stalled, extend, abort_now;

    assign accept_ok = (phase_q == PH_IDLE) && region_en;
    assign accept    = accept_ok && req_valid;
    assign stalled   = (phase_q == PH_STROBE) && at_end && cfg_q.wait_en && !rdy_sync;
    assign extend    = stalled && (wcnt_q != WLIM);
    assign abort_now = stalled && (wcnt_q == WLIM);
    assign advance   = (phase_q != PH_IDLE) && at_end && !extend;

    always_comb begin
        phase_nxt = phase_q;
        if (accept) begin
            phase_nxt = PH_ADDR;
        end else if (advance) begin
            case (phase_q)
                PH_ADDR:   phase_nxt = PH_LEAD;
                PH_LEAD:   phase_nxt = PH_STROBE;
                PH_STROBE: phase_nxt = PH_HOLD;
                PH_HOLD:   phase_nxt = PH_PAUSE;
                default:   phase_nxt = PH_IDLE;
            endcase
        end
    end

    assign tmr_load    = accept || (advance && phase_q != PH_PAUSE);
    assign tmr_units   = accept ? live_cfg.addr_setup : phase_field(phase_nxt, cfg_q, wr_q);
    assign tmr_clocks  = accept ? scale_clocks(live_cfg.scale) : scale_clocks(cfg_q.scale);
    assign tmr_restart = extend;
    assign capture     = advance && (phase_q == PH_STROBE) && !wr_q;
    assign finish      = advance && (phase_q == PH_PAUSE);
    assign aborted     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            wcnt_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_nxt;
            if (accept) begin
                cfg_q   <= live_cfg;
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                err_q   <= 1'b0;
            end
            if (abort_now) err_q <= 1'b1;
            if (tmr_load)    wcnt_q <= '0;
            else if (extend) wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> !accept_ok);
    assert_region_off_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !region_en) |=> (phase_q == PH_IDLE));
    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (rst)
        wcnt_q <= WLIM);
    assert_wait_only_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        extend |=> (phase_q == PH_STROBE));
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int WAIT_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_region_en,
    input  logic              cfg_wait_en,
    input  logic [1:0]        cfg_scale,
    input  logic [5:0]        cfg_addr_setup,
    input  logic [5:0]        cfg_ce_lead,
    input  logic [5:0]        cfg_strobe,
    input  logic [5:0]        cfg_rd_hold,
    input  logic [5:0]        cfg_wr_hold,
    input  logic [5:0]        cfg_pause,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic              timeout_err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ce_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy
);
    timing_t            live_cfg;
    logic               rdy_s, at_end, tmr_load, tmr_restart;
    logic [FIELD_W-1:0] tmr_units;
    logic [TICK_W-1:0]  tmr_clocks;
    phase_e             phase_nxt;
    logic               wr_q, capture, finish, aborted;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;

    assign live_cfg = '{wait_en: cfg_wait_en, scale: cfg_scale,
                        addr_setup: cfg_addr_setup, ce_lead: cfg_ce_lead,
                        strobe: cfg_strobe, rd_hold: cfg_rd_hold,
                        wr_hold: cfg_wr_hold, pause: cfg_pause};

    ebus_rdy_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .rdy_async(bus_rdy), .rdy_sync(rdy_s)
    );

    ebus_phase_timer u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_units(tmr_units),
        .unit_clocks(tmr_clocks), .restart_unit(tmr_restart), .at_end(at_end)
    );

    ebus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
        .clk(clk), .rst(rst), .region_en(cfg_region_en), .live_cfg(live_cfg),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rdy_sync(rdy_s), .at_end(at_end),
        .accept_ok(req_ready), .tmr_load(tmr_load), .tmr_units(tmr_units),
        .tmr_clocks(tmr_clocks), .tmr_restart(tmr_restart), .phase_nxt(phase_nxt),
        .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q), .capture(capture),
        .finish(finish), .aborted(aborted)
    );

    // Pin registers load from the next phase so strobes change on a clean edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ce_n    <= 1'b1;
            bus_oe_n    <= 1'b1;
            bus_we_n    <= 1'b1;
            bus_dout_en <= 1'b0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            rd_data     <= '0;
        end else begin
            bus_ce_n    <= !ce_window(phase_nxt);
            bus_oe_n    <= !((phase_nxt == PH_STROBE) && !wr_q);
            bus_we_n    <= !((phase_nxt == PH_STROBE) && wr_q);
            bus_dout_en <= ce_window(phase_nxt) && wr_q;
            done        <= finish;
            timeout_err <= finish && aborted;
            if (capture) rd_data <= bus_din;
        end
    end

    assign bus_addr = addr_q;
    assign bus_dout = wdata_q;

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(!bus_oe_n && !bus_we_n));
    assert_strobe_in_ce_R1: assert property (@(posedge clk) disable iff (rst)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> done);
    assert_dout_window_R11: assert property (@(posedge clk) disable iff (rst)
        bus_dout_en |-> !bus_ce_n);
    assert_rd_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_oe_n && $past(bus_oe_n)) |-> $stable(rd_data));
endmodule

// File: tb/ebus_seq_bench.sv
module ebus_seq_bench;
    localparam int AW = 24;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          region_en = 1'b0, wait_en = 1'b0;
    logic [1:0]    scale = 2'd1;
    logic [5:0]    t_a = '0, t_c = '0, t_s = '0, t_rh = '0, t_wh = '0, t_p = '0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, bus_din = '0;
    logic          bus_rdy = 1'b1;
    logic          req_ready, done, timeout_err, bus_ce_n, bus_oe_n, bus_we_n, bus_dout_en;
    logic [DW-1:0] rd_data, bus_dout;
    logic [AW-1:0] bus_addr;

    ebus_seq u_ebus_seq (
        .clk(clk), .rst(rst), .cfg_region_en(region_en), .cfg_wait_en(wait_en),
        .cfg_scale(scale), .cfg_addr_setup(t_a), .cfg_ce_lead(t_c), .cfg_strobe(t_s),
        .cfg_rd_hold(t_rh), .cfg_wr_hold(t_wh), .cfg_pause(t_p),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .timeout_err(timeout_err), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    int n_checks = 0, n_fail = 0;
    int ce_low, oe_low, we_low, done_k, release_at;
    logic err_seen, rd_seen, busy_ready, addr_bad, dout_bad, en_bad, order_bad;

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] sc, input int a, c, s, rh, wh, p, input logic we);
        scale = sc; t_a = 6'(a); t_c = 6'(c); t_s = 6'(s);
        t_rh = 6'(rh); t_wh = 6'(wh); t_p = 6'(p); wait_en = we;
    endtask

    // One access; measures pin windows at negedges. release_at>0 raises ready
    // after that many strobe-low samples.
    task automatic run_cycle(input logic wr, input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                             input logic [DW-1:0] din);
        logic seen_oe = 1'b0, swapped = 1'b0, ce_seen = 1'b0, ce_ended = 1'b0;
        ce_low = 0; oe_low = 0; we_low = 0; done_k = -1;
        err_seen = 0; busy_ready = 0; addr_bad = 0; dout_bad = 0; en_bad = 0; order_bad = 0;
        bus_din = din;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
        for (int k = 1; k < 4000; k++) begin
            @(negedge clk);
            if (k == 1) begin req_valid = 1'b0; req_addr = ~ad; req_wdata = ~wd; end
            if (done) begin
                done_k = k; err_seen = timeout_err; rd_seen = rd_data[0];
                break;
            end
            if (req_ready) busy_ready = 1;
            if (bus_addr != ad) addr_bad = 1;
            if (!bus_ce_n) begin ce_low++; ce_seen = 1; if (ce_ended) order_bad = 1; end
            else if (ce_seen) ce_ended = 1;
            if (!bus_oe_n) begin oe_low++; seen_oe = 1; end
            if (!bus_we_n) we_low++;
            if (bus_dout_en != (wr && !bus_ce_n)) en_bad = 1;
            if (bus_dout_en && bus_dout != wd) dout_bad = 1;
            if (seen_oe && bus_oe_n && !swapped) begin bus_din = ~din; swapped = 1; end
            if (release_at > 0 && (oe_low + we_low) == release_at) bus_rdy = 1'b1;
        end
    endtask

    function automatic int mul_of(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 8;
    endfunction

    task automatic t_reset();
        check("R12 ce_n", bus_ce_n == 1'b1, bus_ce_n, 1);
        check("R12 oe_n/we_n", bus_oe_n && bus_we_n, {bus_oe_n, bus_we_n}, 3);
        check("R12 done/err", !done && !timeout_err, {done, timeout_err}, 0);
        check("R12 dout_en", bus_dout_en == 1'b0, bus_dout_en, 0);
    endtask

    task automatic t_region_off();
        int ce_cnt = 0;
        region_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!bus_ce_n || req_ready) ce_cnt++;
        end
        req_valid = 1'b0;
        check("R8 disabled region idle", ce_cnt == 0, ce_cnt, 0);
        region_en = 1'b1;
        @(negedge clk);
        check("R8 ready after enable", req_ready == 1'b1, req_ready, 1);
    endtask

    task automatic t_read();
        int exp_total;
        set_cfg(2'd1, 2, 1, 3, 2, 5, 1, 1'b0);
        run_cycle(1'b0, 24'h12345, 16'h0, 16'hA5C3);
        exp_total = (3 + 2 + 4 + 3 + 2);
        check("R2 read done time", done_k == exp_total + 1, done_k, exp_total + 1);
        check("R1 ce window read", ce_low == 2 + 4 + 3, ce_low, 9);
        check("R2 oe length", oe_low == 4, oe_low, 4);
        check("R4 read no we", we_low == 0, we_low, 0);
        check("R7 read data", rd_data == 16'hA5C3, rd_data, 16'hA5C3);
        check("R9 not ready while busy", !busy_ready, busy_ready, 0);
        check("R11 address held", !addr_bad, addr_bad, 0);
        check("R1 single ce window", !order_bad, order_bad, 0);
        @(negedge clk);
        check("R9 done one pulse", done == 1'b0, done, 0);
    endtask

    task automatic t_write();
        int exp_total;
        set_cfg(2'd2, 0, 2, 1, 6, 3, 0, 1'b0);
        run_cycle(1'b1, 24'h00BEEF, 16'h5A3C, 16'h0);
        exp_total = (1 + 3 + 2 + 4 + 1) * 2;
        check("R2 write hold uses wr field", done_k == exp_total + 1, done_k, exp_total + 1);
        check("R4 write no oe", oe_low == 0, oe_low, 0);
        check("R4 we length", we_low == 4, we_low, 4);
        check("R11 write drive window", !en_bad, en_bad, 0);
        check("R11 write data", !dout_bad, dout_bad, 0);
        check("R1 ce window write", ce_low == 18, ce_low, 18);
    endtask

    task automatic t_scales();
        for (int c = 0; c < 4; c++) begin
            int m = mul_of(2'(c));
            set_cfg(2'(c), 1, 0, 2, 1, 1, 0, 1'b0);
            run_cycle(1'b0, 24'h1, 16'h0, 16'h1111);
            check("R3 scale total", done_k == 9 * m + 1, done_k, 9 * m + 1);
            check("R3 scale strobe", oe_low == 3 * m, oe_low, 3 * m);
        end
    endtask

    task automatic t_wait_ignored();
        set_cfg(2'd1, 0, 0, 1, 0, 0, 0, 1'b0);
        bus_rdy = 1'b0;
        run_cycle(1'b0, 24'h2, 16'h0, 16'h2222);
        bus_rdy = 1'b1;
        check("R6 ready ignored strobe", oe_low == 2, oe_low, 2);
        check("R6 ready ignored total", done_k == 7, done_k, 7);
    endtask

    task automatic t_wait_release();
        set_cfg(2'd1, 0, 0, 1, 0, 0, 0, 1'b1);
        bus_rdy = 1'b0;
        release_at = 10;
        run_cycle(1'b0, 24'h3, 16'h0, 16'h3333);
        release_at = 0;
        bus_rdy = 1'b1;
        check("R5 stretched strobe", oe_low >= 11 && oe_low <= 13, oe_low, 12);
        check("R5 no error on release", err_seen == 1'b0, err_seen, 0);
        check("R7 data after stretch", rd_data == 16'h3333, rd_data, 16'h3333);
    endtask

    task automatic t_timeout();
        set_cfg(2'd1, 0, 0, 2, 0, 0, 0, 1'b1);
        bus_rdy = 1'b0;
        run_cycle(1'b0, 24'h4, 16'h0, 16'h4444);
        bus_rdy = 1'b1;
        check("R10 abort length", oe_low == 3 + 256, oe_low, 259);
        check("R10 error flagged", err_seen == 1'b1, err_seen, 1);
        set_cfg(2'd1, 0, 0, 0, 0, 0, 0, 1'b1);
        run_cycle(1'b0, 24'h5, 16'h0, 16'h5555);
        check("R10 error clears next cycle", err_seen == 1'b0, err_seen, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        release_at = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_region_off();
        t_read();
        t_write();
        t_scales();
        t_wait_ignored();
        t_wait_release();
        t_timeout();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule